// File: doc/BRIEF.md
# Serial Configuration Stream Frame Checker

This block watches a serial configuration stream that arrives one bit per clock, qualified by a valid strobe. It checks the framing of the stream and hands on the payload. The stream opens with a run of one bits. A fixed preamble pattern follows, then a 24-bit length value and a short separator of ones. After this header comes a fixed number of frames. Each frame holds a zero start bit, a parameterised number of payload bits and a constant 4-bit trailer. A fixed end pattern closes the stream.

Payload bits leave the block one at a time, tagged with the index of the frame that carried them. The same bits are also packed into bytes. Any framing violation stops all loading and drives an active-low error line low. The line stays low until the synchronous active-low program input starts a new load. A one-cycle completion pulse marks a stream that ended cleanly.

Top module: `cfg_stream_parser`

## Requirements
- R1: The fill search needs at least 8 consecutive accepted one bits. A zero bit that follows such a run starts the preamble and counts as its first bit. A zero bit after a shorter run only restarts the search and raises no error.
- R2: The preamble is the 4-bit pattern 0010, taken in arrival order with the leftmost bit first. Any mismatch is an error.
- R3: The next 24 accepted bits form the length value, MSB-first: the first bit lands in `lengthCount[23]`. The complete value appears on `lengthCount` one cycle after its last bit.
- R4: A separator of four one bits follows the length value. A zero bit there is an error.
- R5: Every frame begins with a start bit of 0. A 1 in that position is an error.
- R6: Each payload bit appears on `dataBit` with `dataValid` high for one cycle, one cycle after the bit is accepted. `frameIdx` carries the 0-based frame number.
- R7: Each frame ends with the 4-bit trailer 0110, leftmost bit first. Any other value is an error.
- R8: Payload bits are packed into bytes across frame boundaries. The first bit of each byte goes to `byteOut[0]` and the eighth to `byteOut[7]`. `byteValid` pulses in the same cycle that the eighth bit shows on `dataBit`. Bits left over at the end, fewer than 8, are dropped.
- R9: After exactly NUM_FRAMES frames the end pattern 01111111 must follow, leftmost bit first. A mismatch, including one caused by an extra frame, is an error.
- R10: After an error, `initN` goes low one cycle after the offending bit. It stays low while `progN` is high. While it is low, no `dataValid`, `byteValid` or `doneOut` appears.
- R11: `doneOut` pulses for exactly one cycle, one cycle after the last end-pattern bit. Bits that arrive after that are ignored: no error, no payload, no change to `lengthCount`.
- R12: A cycle with `bitValid` low advances nothing, whatever the value of `bitIn`.
- R13: A cycle with `progN` low clears all state at the next edge. `initN` returns high, `doneOut`, `dataValid` and `byteValid` are low, `lengthCount` is zero, and the fill search restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| progN | input | 1 | Synchronous active-low restart of the whole parser |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Serial stream bit |
| initN | output | 1 | Active-low error line, low after a framing error |
| doneOut | output | 1 | One-cycle pulse after a valid end pattern |
| lengthCount | output | 24 | Captured length value |
| dataValid | output | 1 | Payload bit strobe |
| dataBit | output | 1 | Payload bit |
| frameIdx | output | $clog2(NUM_FRAMES) (min 1) | Frame number of the payload bit |
| byteValid | output | 1 | Assembled byte strobe |
| byteOut | output | 8 | Assembled byte, first bit in bit 0 |

## Verification
The hardest case to reach from the ports is a stream that is framed correctly until the frame count runs out. An extra frame is then sent where the end pattern should be. Its start bit matches the first bit of the end pattern, so the error appears only on the second bit of the extra frame. To get there, the bench sends a full valid header and all the expected frames. It then appends one more frame whose first payload bit is zero, and checks that the payload of the good frames still came out, that `initN` fell and that no completion pulse appeared. Every stream also starts with a short false run of ones, and one run spaces its bits with idle cycles that carry inverted data.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int LEN_BITS  = 24;
  localparam int FILL_ONES = 8;

  // Patterns are stored left-justified in 8 bits; stream order is MSB first.
  localparam logic [7:0] PRE_PAT   = 8'b0010_0000;
  localparam logic [7:0] SEP_PAT   = 8'b1111_0000;
  localparam logic [7:0] CHECK_PAT = 8'b0110_0000;
  localparam logic [7:0] POST_PAT  = 8'b0111_1111;

  typedef enum logic [3:0] {
    ST_FILL,
    ST_PRE,
    ST_LEN,
    ST_SEP,
    ST_START,
    ST_DATA,
    ST_CHECK,
    ST_POST,
    ST_DONE,
    ST_ERR
  } parseState_e;

  typedef struct packed {
    logic clearAll;
    logic shiftLen;
    logic emitData;
    logic nextFrame;
  } dpCtrl_t;

endpackage

// File: rtl/cfgp_datapath.sv
module cfgp_datapath
  import cfgp_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 4,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                 clk,
  input  logic                 bitIn,
  input  dpCtrl_t              ctrl,
  output logic                 lastFrame,
  output logic [LEN_BITS-1:0]  lengthCount,
  output logic                 dataValid,
  output logic                 dataBit,
  output logic [IDX_W-1:0]     frameIdx,
  output logic                 byteValid,
  output logic [7:0]           byteOut
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  logic [IDX_W-1:0] frameCnt;
  logic [7:0]       byteReg;
  logic [7:0]       byteNext;
  logic [2:0]       byteCnt;

  assign lastFrame = (frameCnt == LAST_IDX);

  always_comb begin
    byteNext = byteReg;
    byteNext[byteCnt] = bitIn;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearAll) begin
      lengthCount <= '0;
      frameCnt    <= '0;
      byteReg     <= '0;
      byteCnt     <= '0;
      dataValid   <= 1'b0;
      dataBit     <= 1'b0;
      frameIdx    <= '0;
      byteValid   <= 1'b0;
      byteOut     <= '0;
    end else begin
      dataValid <= ctrl.emitData;
      byteValid <= 1'b0;
      if (ctrl.shiftLen) begin
        lengthCount <= {lengthCount[LEN_BITS-2:0], bitIn};
      end
      if (ctrl.emitData) begin
        dataBit  <= bitIn;
        frameIdx <= frameCnt;
        byteCnt  <= byteCnt + 3'd1;
        if (byteCnt == 3'd7) begin
          byteValid <= 1'b1;
          byteOut   <= byteNext;
          byteReg   <= '0;
        end else begin
          byteReg <= byteNext;
        end
      end
      if (ctrl.nextFrame && !lastFrame) begin
        frameCnt <= frameCnt + IDX_W'(1);
      end
    end
  end

  // R6: a payload strobe never names a frame beyond the configured count
  a_r6_frame_in_range: assert property (@(posedge clk) disable iff (ctrl.clearAll)
    dataValid |-> (int'(frameIdx) < NUM_FRAMES))
    else $error("frame index out of range");

  // R8: bytes need eight payload bits, so two byte strobes never touch
  a_r8_byte_spacing: assert property (@(posedge clk) disable iff (ctrl.clearAll)
    byteValid |=> !byteValid)
    else $error("back-to-back byte strobes");

  // R8: a byte strobe only comes with a payload strobe
  a_r8_byte_with_data: assert property (@(posedge clk) disable iff (ctrl.clearAll)
    byteValid |-> dataValid)
    else $error("byte strobe without data strobe");

endmodule

// File: rtl/cfgp_control.sv
module cfgp_control
  import cfgp_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic    clk,
  input  logic    progN,
  input  logic    bitValid,
  input  logic    bitIn,
  input  logic    lastFrame,
  output dpCtrl_t ctrl,
  output logic    initN,
  output logic    doneOut
);

  localparam int CNT_MAX = (FRAME_BITS > LEN_BITS) ? FRAME_BITS : LEN_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] FILL_MIN  = CNT_W'(FILL_ONES);
  localparam logic [CNT_W-1:0] LAST_LEN  = CNT_W'(LEN_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_NIB  = CNT_W'(3);
  localparam logic [CNT_W-1:0] LAST_OCT  = CNT_W'(7);

  parseState_e       state, stateNext;
  logic [CNT_W-1:0]  bitCnt, cntNext;
  logic              doneNext;
  logic [2:0]        patIdx;

  assign patIdx = 3'd7 - bitCnt[2:0];

  function automatic logic patBit(input logic [7:0] pat, input logic [2:0] idx);
    return pat[idx];
  endfunction

  always_comb begin
    stateNext = state;
    cntNext   = bitCnt;
    doneNext  = 1'b0;
    ctrl      = '0;
    if (!progN) begin
      ctrl.clearAll = 1'b1;
      stateNext     = ST_FILL;
      cntNext       = '0;
    end else if (bitValid) begin
      unique case (state)
        ST_FILL: begin
          if (bitIn) begin
            if (bitCnt < FILL_MIN) cntNext = bitCnt + CNT_W'(1);
          end else if (bitCnt >= FILL_MIN) begin
            stateNext = ST_PRE;
            cntNext   = CNT_W'(1);
          end else begin
            cntNext = '0;
          end
        end
        ST_PRE: begin
          if (bitIn != patBit(PRE_PAT, patIdx)) stateNext = ST_ERR;
          else if (bitCnt == LAST_NIB) begin
            stateNext = ST_LEN;
            cntNext   = '0;
          end else cntNext = bitCnt + CNT_W'(1);
        end
        ST_LEN: begin
          ctrl.shiftLen = 1'b1;
          if (bitCnt == LAST_LEN) begin
            stateNext = ST_SEP;
            cntNext   = '0;
          end else cntNext = bitCnt + CNT_W'(1);
        end
        ST_SEP: begin
          if (bitIn != patBit(SEP_PAT, patIdx)) stateNext = ST_ERR;
          else if (bitCnt == LAST_NIB) begin
            stateNext = ST_START;
            cntNext   = '0;
          end else cntNext = bitCnt + CNT_W'(1);
        end
        ST_START: begin
          if (bitIn) stateNext = ST_ERR;
          else begin
            stateNext = ST_DATA;
            cntNext   = '0;
          end
        end
        ST_DATA: begin
          ctrl.emitData = 1'b1;
          if (bitCnt == LAST_DATA) begin
            stateNext = ST_CHECK;
            cntNext   = '0;
          end else cntNext = bitCnt + CNT_W'(1);
        end
        ST_CHECK: begin
          if (bitIn != patBit(CHECK_PAT, patIdx)) stateNext = ST_ERR;
          else if (bitCnt == LAST_NIB) begin
            ctrl.nextFrame = 1'b1;
            stateNext      = lastFrame ? ST_POST : ST_START;
            cntNext        = '0;
          end else cntNext = bitCnt + CNT_W'(1);
        end
        ST_POST: begin
          if (bitIn != patBit(POST_PAT, patIdx)) stateNext = ST_ERR;
          else if (bitCnt == LAST_OCT) begin
            stateNext = ST_DONE;
            doneNext  = 1'b1;
            cntNext   = '0;
          end else cntNext = bitCnt + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state   <= stateNext;
    bitCnt  <= cntNext;
    doneOut <= doneNext;
    initN   <= (stateNext != ST_ERR);
  end

  // R10: the error line holds low until a restart
  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!progN)
    !initN |=> !initN)
    else $error("error line released without restart");

  // R11: completion is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (!progN)
    doneOut |=> !doneOut)
    else $error("done pulse longer than one cycle");

  // R12: an idle cycle leaves the parse position where it was
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!progN)
    (!bitValid && progN) |=> ($stable(state) && $stable(bitCnt)))
    else $error("parser advanced without a valid bit");

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfgp_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 4,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                clk,
  input  logic                progN,
  input  logic                bitValid,
  input  logic                bitIn,
  output logic                initN,
  output logic                doneOut,
  output logic [LEN_BITS-1:0] lengthCount,
  output logic                dataValid,
  output logic                dataBit,
  output logic [IDX_W-1:0]    frameIdx,
  output logic                byteValid,
  output logic [7:0]          byteOut
);

  dpCtrl_t ctrl;
  logic    lastFrame;

  cfgp_control #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk      (clk),
    .progN    (progN),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .lastFrame(lastFrame),
    .ctrl     (ctrl),
    .initN    (initN),
    .doneOut  (doneOut)
  );

  cfgp_datapath #(.FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES)) u_dp (
    .clk        (clk),
    .bitIn      (bitIn),
    .ctrl       (ctrl),
    .lastFrame  (lastFrame),
    .lengthCount(lengthCount),
    .dataValid  (dataValid),
    .dataBit    (dataBit),
    .frameIdx   (frameIdx),
    .byteValid  (byteValid),
    .byteOut    (byteOut)
  );

  // R10: nothing is delivered while the error line is low
  a_r10_quiet_in_error: assert property (@(posedge clk) disable iff (!progN)
    !initN |-> (!dataValid && !byteValid && !doneOut))
    else $error("output activity during error");

  // R13: a restart cycle clears the visible state at the next edge
  a_r13_restart_clear: assert property (@(posedge clk)
    !progN |=> (initN && !doneOut && !dataValid && !byteValid && lengthCount == '0))
    else $error("restart did not clear state");

  // R12: idle cycles produce no payload and keep the length value
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!progN)
    (!bitValid && progN) |=> (!dataValid && $stable(lengthCount)))
    else $error("idle cycle changed outputs");

endmodule

// File: tb/tb_cfg_stream_parser.sv
`timescale 1ns/1ps
module tb_cfg_stream_parser;

  localparam int FB = 6;
  localparam int NF = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic progN, bitValid, bitIn;
  logic initN, doneOut, dataValid, dataBit, byteValid;
  logic [23:0] lengthCount;
  logic [IW-1:0] frameIdx;
  logic [7:0] byteOut;

  int checks = 0;
  int failures = 0;
  int doneSeen = 0;
  bit gapMode = 0;
  bit pushOk = 1;
  logic [7:0] byteAcc;
  int byteN = 0;

  int   expFrame[$];
  logic expBit[$];
  logic [7:0] expByte[$];

  always #4 clk = ~clk;

  cfg_stream_parser #(.FRAME_BITS(FB), .NUM_FRAMES(NF)) dut (
    .clk(clk), .progN(progN), .bitValid(bitValid), .bitIn(bitIn),
    .initN(initN), .doneOut(doneOut), .lengthCount(lengthCount),
    .dataValid(dataValid), .dataBit(dataBit), .frameIdx(frameIdx),
    .byteValid(byteValid), .byteOut(byteOut)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as payload and bytes leave the design
  always @(negedge clk) begin
    if (progN && doneOut) doneSeen++;
    if (progN && dataValid) begin
      if (expBit.size() == 0) begin
        check(0, "R10/R11 unexpected dataValid", 1, 0);
      end else begin
        int ef;
        logic eb;
        ef = expFrame.pop_front();
        eb = expBit.pop_front();
        check(dataBit == eb, "R6 dataBit", dataBit, eb);
        check(int'(frameIdx) == ef, "R6 frameIdx", frameIdx, ef);
      end
    end
    if (progN && byteValid) begin
      if (expByte.size() == 0) begin
        check(0, "R8 unexpected byteValid", 1, 0);
      end else begin
        logic [7:0] ey;
        ey = expByte.pop_front();
        check(byteOut == ey, "R8 byteOut", byteOut, ey);
      end
    end
  end

  task automatic sb(input logic b);
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
    if (gapMode) begin
      bitIn = ~b;  // R12: ignored while bitValid is low
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic sendField(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) sb(v[i]);
  endtask

  task automatic sendData(input int f, input logic b);
    if (pushOk) begin
      expFrame.push_back(f);
      expBit.push_back(b);
      byteAcc[byteN] = b;
      byteN++;
      if (byteN == 8) begin
        expByte.push_back(byteAcc);
        byteN = 0;
      end
    end
    sb(b);
  endtask

  task automatic restart();
    progN = 1'b0;
    @(negedge clk);
    progN = 1'b1;
    expFrame.delete(); expBit.delete(); expByte.delete();
    byteN = 0; byteAcc = '0; doneSeen = 0; pushOk = 1;
  endtask

  // kind: 0 good, 1 bad preamble, 2 bad separator, 3 bad start bit,
  // 4 bad trailer, 5 extra frame, 6 bad end pattern
  task automatic runStream(input int kind, input logic [23:0] lenVal);
    int nf;
    nf = (kind == 5) ? NF + 1 : NF;
    if (kind == 1 || kind == 2) pushOk = 0;
    sendField(32'b1110, 4);              // R1: short run then zero, no error
    check(initN == 1'b1, "R1 false start no error", initN, 1);
    sendField(32'h1FF, 9);               // fill
    sendField((kind == 1) ? 32'b0011 : 32'b0010, 4);
    sendField({8'h0, lenVal}, 24);
    sendField((kind == 2) ? 32'b1101 : 32'b1111, 4);
    for (int f = 0; f < nf; f++) begin
      if (f == NF) pushOk = 0;
      if (kind == 3 && f == 1) begin pushOk = 0; sb(1'b1); end
      else sb(1'b0);
      for (int j = 0; j < FB; j++)
        sendData(f, (f == NF && j == 0) ? 1'b0 : logic'(((f + j) % 3) == 0 || j == FB - 1));
      if (kind == 4 && f == 0) begin
        sendField(32'b0111, 4);
        check(initN == 1'b0, "R10 initN low one cycle after bad bit", initN, 0);
        pushOk = 0;
      end else sendField(32'b0110, 4);
    end
    sendField((kind == 6) ? 32'b01111110 : 32'b01111111, 8);
    repeat (3) @(negedge clk);
  endtask

  task automatic endChecks(input int kind, input logic [23:0] lenVal);
    check(initN == (kind == 0), $sformatf("R10 initN kind %0d", kind), initN, kind == 0);
    check(doneSeen == ((kind == 0) ? 1 : 0), $sformatf("R11 done count kind %0d", kind),
          doneSeen, (kind == 0) ? 1 : 0);
    check(expBit.size() == 0, $sformatf("R6 missing payload kind %0d", kind), expBit.size(), 0);
    check(expByte.size() == 0, $sformatf("R8 missing bytes kind %0d", kind), expByte.size(), 0);
    if (kind != 1 && kind != 2 && kind != 0)
      check(lengthCount == lenVal, "R3 lengthCount", lengthCount, lenVal);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    progN = 1'b0; bitValid = 1'b0; bitIn = 1'b0;
    repeat (3) @(negedge clk);
    check(initN == 1'b1, "R13 reset initN", initN, 1);
    check(doneOut == 1'b0, "R13 reset doneOut", doneOut, 0);
    check(dataValid == 1'b0, "R13 reset dataValid", dataValid, 0);
    check(lengthCount == 24'd0, "R13 reset lengthCount", lengthCount, 0);
    restart();

    // R2 R3 R4 R5 R7 R9 good stream
    runStream(0, 24'hA5C30F);
    check(lengthCount == 24'hA5C30F, "R3 lengthCount MSB-first", lengthCount, 24'hA5C30F);
    endChecks(0, 24'hA5C30F);

    // R11: bits after completion are ignored
    sendField(32'h0F0F0, 20);
    repeat (2) @(negedge clk);
    check(initN == 1'b1, "R11 no error after done", initN, 1);
    check(doneSeen == 1, "R11 no second done", doneSeen, 1);
    check(lengthCount == 24'hA5C30F, "R11 length kept", lengthCount, 24'hA5C30F);

    // R12: gapped stream with inverted idle data
    restart();
    check(lengthCount == 24'd0, "R13 restart clears length", lengthCount, 0);
    gapMode = 1;
    runStream(0, 24'h13579B);
    gapMode = 0;
    check(lengthCount == 24'h13579B, "R12 gapped length", lengthCount, 24'h13579B);
    endChecks(0, 24'h13579B);

    // error kinds
    for (int k = 1; k <= 6; k++) begin
      restart();
      runStream(k, 24'h00C0DE + 24'(k));
      sendField(32'b0_101010_0110, 11);   // R10: further bits do nothing
      repeat (2) @(negedge clk);
      endChecks(k, 24'h00C0DE + 24'(k));
    end

    // R13: restart from the error state, then mid-stream restart
    restart();
    check(initN == 1'b1, "R13 initN released by restart", initN, 1);
    sendField(32'h1FF, 9);
    sendField(32'b0010, 4);
    sendField(32'h00ABCD, 24);
    restart();
    check(lengthCount == 24'd0, "R13 mid-stream restart clears length", lengthCount, 0);
    runStream(0, 24'h7E0001);
    endChecks(0, 24'h7E0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule